// File: doc/BRIEF.md
# Multiplexer Scan Waveform Sequencer

This block drives the three control lines of a multichannel analog front end that contains an input multiplexer followed by an ADC. STEP moves the multiplexer on to the next channel. CNV starts a conversion. The active-low RESET_N sends the multiplexer back to its first channel. The pulse timebase is an up/down counter. STEP is high while the counter climbs and low while it falls, so STEP has a 50% duty cycle. CNV is the inverse of STEP.

Pulse periods are grouped into frames of eight slots. The first seven slots each carry one STEP pulse. In the eighth slot the frame signal pulls RESET_N low for a whole pulse period. The low interval starts and ends on a counter zero, so every STEP pulse is complete. RESET_N gates STEP and CNV on every clock, and the counter never has to be reprogrammed to produce the gap.

At each counter zero the block raises a one-cycle ready strobe, tagged with the current slot index, so that the data read from the front end can be matched to its channel. When the enable input drops, RESET_N goes low and both pulse lines stay low until operation resumes.

Top module: `mux_scan_seq`

## Requirements
- R1: While the synchronous reset is held, and afterwards until enable is sampled high, stepOut, cnvOut, resetNOut and readyOut are all 0.
- R2: With a half period P in force, each slot lasts 2P clocks. stepOut is 1 for the first P clocks of the slot and 0 for the last P clocks.
- R3: Outside the blanked slot, cnvOut equals the inverse of stepOut on every clock. stepOut and cnvOut are never 1 together.
- R4: A frame has slots 0 to 7. In slots 0 to 6, resetNOut is 1. In slot 7, resetNOut, stepOut and cnvOut are 0 for all 2P clocks of the slot. After slot 7 comes slot 0.
- R5: readyOut is 1 for exactly one clock, the first clock of each slot (the counter-zero clock), and readyChan then gives that slot's index, 0 to 7.
- R6: halfPeriod is sampled only in the counter-zero clock. A value changed in the middle of a slot takes effect from the next slot onwards.
- R7: A halfPeriod value below 2 is used as 2.
- R8: If enable is sampled low at a clock edge, all four outputs are 0 from that edge until enable is sampled high again.
- R9: When enable is sampled high after a stop, the next clock is the first clock of slot 0: readyOut is 1 with readyChan 0, and stepOut is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the sequencer when high |
| halfPeriod | input | CNT_W | Clocks per counting direction of the pulse timebase |
| stepOut | output | 1 | Multiplexer advance pulse |
| cnvOut | output | 1 | Conversion start, the inverse of STEP while not blanked |
| resetNOut | output | 1 | Active-low multiplexer return-to-first-channel |
| readyOut | output | 1 | One-cycle strobe at each counter zero |
| readyChan | output | SLOT_W | Slot index carried with the strobe |

## Verification
The bench uses the default widths: a 16-bit counter and a 3-bit slot index, which gives eight slots per frame. It runs with half periods of 3 and 5, and with 0, which must be read as 2. This keeps each frame between 32 and 80 clocks, so the bench can compare every clock of several complete frames, including the slot 7 blanking and the wrap from slot 7 to slot 0.

The halfPeriod changes are placed a few clocks before a slot boundary. This checks that the slot already in progress keeps its old length. The bench also stops and restarts the block in the middle of a frame, and checks the reset state.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  // Strobes passed from the timebase datapath to the frame control.
  typedef struct packed {
    logic atZero;    // first clock of a slot (counter at zero, counting up)
    logic lastTick;  // last clock of a slot (counter at one, counting down)
    logic highPhase; // counting up and not yet at the peak
  } tbEvt_t;
endpackage

// File: rtl/scan_seq_timebase.sv
module scan_seq_timebase
  import scan_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] halfPeriod,
  output tbEvt_t           evt
);
  localparam logic [CNT_W-1:0] MIN_HALF = 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] periodReg;
  logic [CNT_W-1:0] effHalf;
  logic             countUp;

  assign effHalf = (halfPeriod < MIN_HALF) ? MIN_HALF : halfPeriod;

  always_comb begin
    evt.atZero    = run && countUp && (cnt == '0);
    evt.lastTick  = run && !countUp && (cnt == CNT_W'(1));
    evt.highPhase = countUp && (cnt != periodReg);
  end

  // The period register is loaded only at the counter zero (or while idle).
  always_ff @(posedge clk) begin
    if (rst) begin
      periodReg <= MIN_HALF;
    end else if (evt.atZero || !run) begin
      periodReg <= effHalf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt     <= '0;
      countUp <= 1'b1;
    end else if (countUp) begin
      if (cnt == periodReg) begin
        cnt     <= cnt - CNT_W'(1);
        countUp <= 1'b0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else begin
      if (cnt == CNT_W'(1)) begin
        cnt     <= '0;
        countUp <= 1'b1;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  p_cnt_bound_r2 : assert property (@(posedge clk) disable iff (rst)
    cnt <= periodReg);

  p_period_hold_r6 : assert property (@(posedge clk) disable iff (rst)
    (run && !evt.atZero) |=> $stable(periodReg));

  p_min_half_r7 : assert property (@(posedge clk) disable iff (rst)
    periodReg >= MIN_HALF);
endmodule

// File: rtl/scan_seq_frame.sv
module scan_seq_frame
  import scan_seq_pkg::*;
#(
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  tbEvt_t            evt,
  output logic              run,
  output logic              stepOut,
  output logic              cnvOut,
  output logic              resetNOut,
  output logic              readyOut,
  output logic [SLOT_W-1:0] readyChan
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = '1;

  logic              runQ;
  logic [SLOT_W-1:0] slot;
  logic              blankSlot;

  always_ff @(posedge clk) begin
    if (rst) begin
      runQ <= 1'b0;
      slot <= '0;
    end else begin
      runQ <= enable;
      if (!runQ) begin
        slot <= '0;
      end else if (evt.lastTick) begin
        slot <= slot + SLOT_W'(1);
      end
    end
  end

  assign blankSlot = (slot == LAST_SLOT);
  assign run       = runQ;
  assign resetNOut = runQ && !blankSlot;
  assign stepOut   = resetNOut && evt.highPhase;
  assign cnvOut    = resetNOut && !evt.highPhase;
  assign readyOut  = evt.atZero;
  assign readyChan = slot;

  p_excl_r3 : assert property (@(posedge clk) disable iff (rst)
    !(stepOut && cnvOut));

  p_blank_chan_r4 : assert property (@(posedge clk) disable iff (rst)
    (readyOut && readyChan == LAST_SLOT) |-> (!resetNOut && !stepOut));

  p_ready_single_r5 : assert property (@(posedge clk) disable iff (rst)
    readyOut |=> !readyOut);

  p_stop_r8 : assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!resetNOut && !readyOut && !stepOut && !cnvOut));
endmodule

// File: rtl/mux_scan_seq.sv
module mux_scan_seq
  import scan_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [CNT_W-1:0]  halfPeriod,
  output logic              stepOut,
  output logic              cnvOut,
  output logic              resetNOut,
  output logic              readyOut,
  output logic [SLOT_W-1:0] readyChan
);
  tbEvt_t evt;
  logic   run;

  scan_seq_timebase #(.CNT_W(CNT_W)) timebase_i (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .halfPeriod (halfPeriod),
    .evt        (evt)
  );

  scan_seq_frame #(.SLOT_W(SLOT_W)) frame_i (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .evt       (evt),
    .run       (run),
    .stepOut   (stepOut),
    .cnvOut    (cnvOut),
    .resetNOut (resetNOut),
    .readyOut  (readyOut),
    .readyChan (readyChan)
  );
endmodule

// File: tb/mux_scan_seq_tb_top.sv
module mux_scan_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int SLOT_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              enable = 1'b0;
  logic [CNT_W-1:0]  halfPeriod = CNT_W'(3);
  logic              stepOut, cnvOut, resetNOut, readyOut;
  logic [SLOT_W-1:0] readyChan;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic       step;
    logic       cnv;
    logic       rstn;
    logic       rdy;
    logic [2:0] ch;
    string      tag;
  } exp_t;

  exp_t expQ[$];

  mux_scan_seq #(.CNT_W(CNT_W), .SLOT_W(SLOT_W)) dut_i (
    .clk(clk), .rst(rst), .enable(enable), .halfPeriod(halfPeriod),
    .stepOut(stepOut), .cnvOut(cnvOut), .resetNOut(resetNOut),
    .readyOut(readyOut), .readyChan(readyChan)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected frame: slots 0..6 carry a pulse, slot 7 is blanked (R2, R3, R4, R5).
  task automatic pushFrame(input int p, input string tag);
    for (int s = 0; s < 8; s++) begin
      for (int i = 0; i < 2*p; i++) begin
        exp_t e;
        e.rstn = (s != 7);
        e.step = (s != 7) && (i < p);
        e.cnv  = (s != 7) && (i >= p);
        e.rdy  = (i == 0);
        e.ch   = 3'(s);
        e.tag  = tag;
        expQ.push_back(e);
      end
    end
  endtask

  task automatic pushSlot0Head(input int n, input int p, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.rstn = 1'b1; e.step = (i < p); e.cnv = (i >= p);
      e.rdy = (i == 0); e.ch = 3'd0; e.tag = tag;
      expQ.push_back(e);
    end
  endtask

  task automatic pushIdle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.rstn = 1'b0; e.step = 1'b0; e.cnv = 1'b0; e.rdy = 1'b0;
      e.ch = 3'd0; e.tag = tag;
      expQ.push_back(e);
    end
  endtask

  task automatic cmp(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Monitor: one expected item per clock, sampled a quarter period after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        cmp({e.tag, "/R2"}, "step", stepOut, e.step);
        cmp({e.tag, "/R3"}, "cnv", cnvOut, e.cnv);
        cmp({e.tag, "/R4"}, "resetN", resetNOut, e.rstn);
        cmp({e.tag, "/R5"}, "ready", readyOut, e.rdy);
        if (e.rdy) begin
          checks++;
          if (readyChan !== e.ch) begin
            errors++;
            $display("FAIL %s/R5 chan actual %0d expected %0d at %0t", e.tag, readyChan, e.ch, $time);
          end
        end
      end
    end
  end

  // Driver
  initial begin
    pushIdle(4, "R1");                      // reset state
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;                          // R9 start at slot 0
    pushFrame(3, "R9");
    pushFrame(3, "R2");
    repeat (93) @(negedge clk);
    halfPeriod = CNT_W'(5);                 // R6 mid-slot change
    pushFrame(5, "R6");
    repeat (80) @(negedge clk);
    halfPeriod = '0;                        // R7 clamp to 2
    pushFrame(2, "R7");
    pushSlot0Head(2, 2, "R7");
    repeat (37) @(negedge clk);
    enable = 1'b0;                          // R8 stop mid-frame
    pushIdle(6, "R8");
    repeat (6) @(negedge clk);
    enable = 1'b1;                          // R9 restart at slot 0
    pushFrame(2, "R9");
    repeat (40) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2 queue left %0d expected 0", expQ.size());
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule